// File: doc/BRIEF.md
# Banked Edge-Latched Interrupt Vector Controller

This block gathers up to 256 edge-type interrupt sources into 32-vector banks and reports each bank to an upstream interrupt controller on its own summary line. Every source passes through a synchronizer, and a rising edge of the synchronized level latches a pending bit. The pending bit stays set until software acknowledges it by writing a one to that bit.

Each bank has a pending (cause) word and a mask (enable) word, both on a small 32-bit register bus with single-cycle requests. A bank's summary line is the registered OR, across the bank, of pending AND enabled. The number of banks is a parameter from 1 to 8. Vector n belongs to bank n/32 at bit n%32.

Software brings the block to a clean state by writing zero to every enable word and all-ones to every cause word. Pending bits latch whether or not the vector is enabled, so unmasking a vector that is already pending raises the bank line straight away.

Top module: `irq_vec_bank_ctrl`

## Requirements
- R1: After hardware reset every cause bit, every enable bit, every bank line and the read data are 0.
- R2: Vector n maps to bank n/32, bit n%32. The cause word of bank i sits at byte offset 4*i and the enable word of bank i at byte offset 0x20 + 4*i.
- R3: A write to an enable word stores all 32 bits and a read returns them. An enable word changes only when it is written. A 1 unmasks the vector and a 0 masks it.
- R4: A rising edge on a source, after a two-stage synchronizer, sets its cause bit on the third clock edge after the input changes. A source that stays at one level sets nothing.
- R5: Writing a cause word clears every bit written as 1 and leaves bits written as 0 unchanged.
- R6: When a new edge and a write-one-to-clear reach the same cause bit in the same cycle, the bit ends up set.
- R7: Cause bits latch whatever the enable value is. A bank line is 1 one cycle after the cycle in which that bank has some bit both pending and enabled, and is 0 otherwise.
- R8: A source held high after its cause bit has been cleared does not set the bit again until it falls and then rises.
- R9: An address whose two low bits are nonzero, whose offset is 0x40 or above, or that selects a bank at or above the bank count is unmapped. Reads of it return 0 and writes to it change nothing.
- R10: Read data is valid in the cycle after the read request and is 0 in every cycle that follows a cycle with no read request.
- R11: The software reset sequence (0 to all enable words, all-ones to all cause words) leaves all cause bits at 0 and all bank lines at 0 while the sources hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| irq_src | input | NUM_BANKS*32 | Interrupt source levels, vector n on bit n |
| reg_valid | input | 1 | Register request valid |
| reg_write | input | 1 | 1 for a write request, 0 for a read request |
| reg_addr | input | ADDR_W | Byte address of the request |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after the request |
| parent_irq | output | NUM_BANKS | One summary line per bank |

## Verification
The assertions assume that the sources are levels that may change at any time, and that the register bus presents at most one request per cycle, with reg_write sampled only when reg_valid is high. The stimulus changes sources and bus signals shortly after a rising clock edge, so each change is seen at the next edge. Sources are held long enough for the synchronizer to pass each edge. The same-cycle set-and-clear case is aligned by counting the three register stages between a source change and its cause bit.

// File: rtl/ivc_pkg.sv
package ivc_pkg;

  localparam int VEC_PER_BANK = 32;
  localparam int MAX_BANKS    = 8;
  localparam int BANK_IDX_W   = 3;

  typedef logic [VEC_PER_BANK-1:0] vec_word_t;

  // Decoded register select
  typedef struct packed {
    logic                  hit;
    logic                  is_enable;
    logic [BANK_IDX_W-1:0] bank;
  } reg_sel_t;

endpackage

// File: rtl/ivc_edge_sync.sv
module ivc_edge_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] src_i,
  output logic [WIDTH-1:0] rise_o
);

  logic [STAGES-1:0][WIDTH-1:0] chain_q;
  logic [STAGES-1:0][WIDTH-1:0] chain_d;
  logic [WIDTH-1:0]             prev_q;
  logic [WIDTH-1:0]             prev_d;
  logic                         shift_en;

  assign shift_en = 1'b1;

  always_comb begin
    chain_d[0] = src_i;
    for (int s = 1; s < STAGES; s++) begin
      chain_d[s] = chain_q[s-1];
    end
    prev_d = chain_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= '0;
    end else if (shift_en) begin
      chain_q <= chain_d;
      prev_q  <= prev_d;
    end
  end

  assign rise_o = chain_q[STAGES-1] & ~prev_q;

  // A detected rise must come from a low previous sample
  AST_RISE_FROM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise_o) |=> ((prev_q & $past(rise_o)) == $past(rise_o))); // R4

endmodule

// File: rtl/ivc_bank.sv
module ivc_bank
  import ivc_pkg::*;
#(
  parameter int WIDTH = VEC_PER_BANK
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] rise_i,
  input  logic             wr_cause_i,
  input  logic             wr_enable_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] cause_o,
  output logic [WIDTH-1:0] enable_o,
  output logic             parent_o
);

  logic [WIDTH-1:0] cause_q, cause_d;
  logic [WIDTH-1:0] enable_q, enable_d;
  logic             parent_q, parent_d;
  logic [WIDTH-1:0] clr_mask;
  logic             cause_en;

  always_comb begin
    clr_mask = wr_cause_i ? wdata_i : '0;
    // a new edge beats an acknowledge of the same bit
    cause_d  = (cause_q & ~clr_mask) | rise_i;
    cause_en = wr_cause_i | (|rise_i);
    enable_d = wdata_i;
    parent_d = |(cause_q & enable_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
    end else if (cause_en) begin
      cause_q <= cause_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q <= '0;
    end else if (wr_enable_i) begin
      enable_q <= enable_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      parent_q <= 1'b0;
    end else begin
      parent_q <= parent_d;
    end
  end

  assign cause_o  = cause_q;
  assign enable_o = enable_q;
  assign parent_o = parent_q;

  AST_EDGE_SETS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise_i) |=> ((cause_q & $past(rise_i)) == $past(rise_i))); // R6

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cause_i && ((wdata_i & rise_i) == '0)) |=> ((cause_q & $past(wdata_i)) == '0)); // R5

  AST_NO_SET_WITHOUT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((cause_q & ~$past(cause_q) & ~$past(rise_i)) == '0)); // R4

  AST_ENABLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_enable_i |=> $stable(enable_q)); // R3

  AST_ENABLE_STORES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_enable_i |=> (enable_q == $past(wdata_i))); // R3

  AST_MASKED_LINE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_q == '0) |=> !parent_o); // R7

endmodule

// File: rtl/ivc_regif.sv
module ivc_regif
  import ivc_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int ADDR_W    = 8
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    req_valid_i,
  input  logic                                    req_write_i,
  input  logic [ADDR_W-1:0]                       req_addr_i,
  input  logic [NUM_BANKS-1:0][VEC_PER_BANK-1:0]  cause_i,
  input  logic [NUM_BANKS-1:0][VEC_PER_BANK-1:0]  enable_i,
  output logic [NUM_BANKS-1:0]                    wr_cause_o,
  output logic [NUM_BANKS-1:0]                    wr_enable_o,
  output logic [VEC_PER_BANK-1:0]                 rdata_o
);

  localparam int WORD_LSB  = 2;
  localparam int FIELD_MSB = WORD_LSB + BANK_IDX_W;   // bit 5 picks the enable array
  localparam int HIGH_LSB  = FIELD_MSB + 1;

  reg_sel_t               sel;
  logic                   rd_req;
  logic                   wr_req;
  logic [VEC_PER_BANK-1:0] rd_word;
  logic [VEC_PER_BANK-1:0] rdata_q, rdata_d;

  always_comb begin
    sel.bank      = req_addr_i[FIELD_MSB-1:WORD_LSB];
    sel.is_enable = req_addr_i[FIELD_MSB];
    sel.hit       = (req_addr_i[WORD_LSB-1:0] == '0) &&
                    (req_addr_i[ADDR_W-1:HIGH_LSB] == '0) &&
                    (int'(sel.bank) < NUM_BANKS);
  end

  assign rd_req = req_valid_i & ~req_write_i;
  assign wr_req = req_valid_i &  req_write_i;

  always_comb begin
    wr_cause_o  = '0;
    wr_enable_o = '0;
    rd_word     = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (sel.hit && (int'(sel.bank) == b)) begin
        wr_cause_o[b]  = wr_req & ~sel.is_enable;
        wr_enable_o[b] = wr_req &  sel.is_enable;
        rd_word        = sel.is_enable ? enable_i[b] : cause_i[b];
      end
    end
    rdata_d = (rd_req && sel.hit) ? rd_word : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else begin
      rdata_q <= rdata_d;
    end
  end

  assign rdata_o = rdata_q;

  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !sel.hit) |=> (rdata_o == '0)); // R9

  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> (rdata_o == '0)); // R10

  AST_ONE_WRITE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({wr_cause_o, wr_enable_o}) <= 1); // R2

  AST_UNMAPPED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel.hit) |-> ({wr_cause_o, wr_enable_o} == '0)); // R9

endmodule

// File: rtl/irq_vec_bank_ctrl.sv
module irq_vec_bank_ctrl
  import ivc_pkg::*;
#(
  parameter int NUM_BANKS   = 8,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_BANKS*VEC_PER_BANK-1:0] irq_src,
  input  logic                           reg_valid,
  input  logic                           reg_write,
  input  logic [ADDR_W-1:0]              reg_addr,
  input  logic [VEC_PER_BANK-1:0]        reg_wdata,
  output logic [VEC_PER_BANK-1:0]        reg_rdata,
  output logic [NUM_BANKS-1:0]           parent_irq
);

  localparam int NUM_VEC = NUM_BANKS * VEC_PER_BANK;

  // reset: asserted asynchronously, released on a clock edge
  logic [RST_STAGES-1:0] rst_pipe_q;
  logic                  rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[RST_STAGES-2:0], 1'b1};
    end
  end

  assign rst_int_n = rst_pipe_q[RST_STAGES-1];

  logic [NUM_VEC-1:0]                      rise_all;
  logic [NUM_BANKS-1:0][VEC_PER_BANK-1:0]  cause_all;
  logic [NUM_BANKS-1:0][VEC_PER_BANK-1:0]  enable_all;
  logic [NUM_BANKS-1:0]                    wr_cause;
  logic [NUM_BANKS-1:0]                    wr_enable;

  ivc_edge_sync #(
    .WIDTH  (NUM_VEC),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .src_i  (irq_src),
    .rise_o (rise_all)
  );

  ivc_regif #(
    .NUM_BANKS (NUM_BANKS),
    .ADDR_W    (ADDR_W)
  ) u_regif (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .req_valid_i (reg_valid),
    .req_write_i (reg_write),
    .req_addr_i  (reg_addr),
    .cause_i     (cause_all),
    .enable_i    (enable_all),
    .wr_cause_o  (wr_cause),
    .wr_enable_o (wr_enable),
    .rdata_o     (reg_rdata)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    ivc_bank #(
      .WIDTH (VEC_PER_BANK)
    ) u_bank (
      .clk         (clk),
      .rst_n       (rst_int_n),
      .rise_i      (rise_all[b*VEC_PER_BANK +: VEC_PER_BANK]),
      .wr_cause_i  (wr_cause[b]),
      .wr_enable_i (wr_enable[b]),
      .wdata_i     (reg_wdata),
      .cause_o     (cause_all[b]),
      .enable_o    (enable_all[b]),
      .parent_o    (parent_irq[b])
    );

    AST_LINE_FOLLOWS_PENDING: assert property (@(posedge clk) disable iff (!rst_int_n)
      ((cause_all[b] & enable_all[b]) != '0) |=> parent_irq[b]); // R7
  end

  initial begin
    AST_BANK_RANGE: assert (NUM_BANKS >= 1 && NUM_BANKS <= MAX_BANKS && RST_STAGES >= 2 && SYNC_STAGES >= 2); // R2
  end

endmodule

// File: tb/sim_irq_vec_bank_ctrl.sv
`timescale 1ns/1ps
module sim_irq_vec_bank_ctrl;

  localparam int NB  = 6;
  localparam int NV  = NB * 32;
  localparam int AW  = 8;

  logic            clk;
  logic            rst_n;
  logic [NV-1:0]   irq_src;
  logic            reg_valid;
  logic            reg_write;
  logic [AW-1:0]   reg_addr;
  logic [31:0]     reg_wdata;
  logic [31:0]     reg_rdata;
  logic [NB-1:0]   parent_irq;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  bit pend   = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  irq_vec_bank_ctrl #(.NUM_BANKS(NB), .ADDR_W(AW)) u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_src    (irq_src),
    .reg_valid  (reg_valid),
    .reg_write  (reg_write),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .parent_irq (parent_irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops the expected read data one cycle after each read
  always @(negedge clk) begin
    if (pend) begin
      if (exp_q.size() == 0) begin
        chk("scoreboard underflow", reg_rdata, 32'hx);
      end else begin
        chk(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
      end
    end
    pend = reg_valid && !reg_write && rst_n;
  end

  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic bus_write(logic [AW-1:0] a, logic [31:0] d);
    @(posedge clk); #1;
    reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_valid = 1'b0; reg_write = 1'b0;
  endtask

  task automatic bus_read(logic [AW-1:0] a, logic [31:0] exp, string tag);
    @(posedge clk); #1;
    reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(posedge clk); #1;
    reg_valid = 1'b0;
  endtask

  task automatic chk_parent(logic [NB-1:0] exp, string tag);
    @(negedge clk);
    chk(tag, 32'(parent_irq), 32'(exp));
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; irq_src = '0; reg_valid = 1'b0; reg_write = 1'b0;
    reg_addr = '0; reg_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 bank lines in reset", 32'(parent_irq), 32'h0);
    chk("R1 read data in reset", reg_rdata, 32'h0);
    @(posedge clk); #1; rst_n = 1'b1;
    idle(4);
    bus_read(8'h00, 32'h0, "R1 cause0 after reset");
    bus_read(8'h2C, 32'h0, "R1 enable3 after reset");

    // R3 enable read/write
    bus_write(8'h24, 32'hA5A5_0F0F);
    bus_read (8'h24, 32'hA5A5_0F0F, "R3 enable1 readback");
    bus_write(8'h34, 32'h1234_5678);
    bus_read (8'h34, 32'h1234_5678, "R3 enable5 readback");
    bus_read (8'h20, 32'h0, "R3 enable0 untouched");

    // R2/R4 vector 37 -> bank1 bit5 (masked)
    @(posedge clk); #1; irq_src[37] = 1'b1;
    idle(5);
    bus_read(8'h04, 32'h0000_0020, "R2 R4 vector37 in cause1");
    bus_read(8'h00, 32'h0, "R2 cause0 unaffected");
    idle(2);
    chk_parent('0, "R7 masked pending keeps line low");

    // R7 unmask an already pending vector
    bus_write(8'h24, 32'hA5A5_0F2F);
    idle(2);
    chk_parent(6'b000010, "R7 line high after unmask");

    // R5 write-one-to-clear
    bus_write(8'h04, 32'hFFFF_FFDF);
    bus_read (8'h04, 32'h0000_0020, "R5 zero bit left set");
    bus_write(8'h04, 32'h0000_0020);
    bus_read (8'h04, 32'h0, "R5 one bit cleared");
    idle(2);
    chk_parent('0, "R7 line low after clear");

    // R8 held level does not re-set
    idle(5);
    bus_read(8'h04, 32'h0, "R8 held high no re-set");
    @(posedge clk); #1; irq_src[37] = 1'b0;
    idle(4);
    @(posedge clk); #1; irq_src[37] = 1'b1;
    idle(5);
    bus_read(8'h04, 32'h0000_0020, "R8 new rise sets again");
    bus_write(8'h04, 32'h0000_0020);

    // R2 highest vector 191 -> bank5 bit31
    @(posedge clk); #1; irq_src[191] = 1'b1;
    idle(5);
    bus_read(8'h14, 32'h8000_0000, "R2 vector191 in cause5");
    bus_read(8'h10, 32'h0, "R2 cause4 unaffected");
    chk_parent('0, "R7 bank5 bit31 masked");

    // R6 edge and clear in the same cycle on vector 67 (bank2 bit3)
    @(posedge clk); #1; irq_src[67] = 1'b1;
    @(posedge clk);
    @(posedge clk); #1;
    reg_valid = 1'b1; reg_write = 1'b1; reg_addr = 8'h08; reg_wdata = 32'h0000_0008;
    @(posedge clk); #1;
    reg_valid = 1'b0; reg_write = 1'b0;
    bus_read(8'h08, 32'h0000_0008, "R6 set wins over clear");
    bus_write(8'h08, 32'h0000_0008);
    bus_read(8'h08, 32'h0, "R5 later clear takes effect");

    // R9 unmapped addresses
    bus_write(8'h18, 32'hFFFF_FFFF);
    bus_read (8'h18, 32'h0, "R9 bank6 cause unmapped");
    bus_write(8'h38, 32'hFFFF_FFFF);
    bus_read (8'h38, 32'h0, "R9 bank6 enable unmapped");
    bus_write(8'h25, 32'h0);
    bus_read (8'h24, 32'hA5A5_0F2F, "R9 misaligned write ignored");
    bus_read (8'h21, 32'h0, "R9 misaligned read zero");
    bus_read (8'h40, 32'h0, "R9 offset 0x40 zero");
    bus_write(8'hA4, 32'h0);
    bus_read (8'hA4, 32'h0, "R9 high address read zero");
    bus_read (8'h24, 32'hA5A5_0F2F, "R9 high address write ignored");

    // R10 data returns to zero without a read
    @(posedge clk);
    @(negedge clk);
    chk("R10 idle read data zero", reg_rdata, 32'h0);

    // R11 software reset sequence
    @(posedge clk); #1; irq_src[0] = 1'b1; irq_src[100] = 1'b1;
    idle(5);
    bus_write(8'h20, 32'hFFFF_FFFF);
    bus_write(8'h2C, 32'h0000_0010);
    idle(2);
    chk_parent(6'b001001, "R7 banks 0 and 3 raised");
    for (int b = 0; b < NB; b++) begin
      bus_write(8'(8'h20 + 4 * b), 32'h0);
      bus_write(8'(4 * b), 32'hFFFF_FFFF);
    end
    idle(3);
    for (int b = 0; b < NB; b++) begin
      bus_read(8'(4 * b), 32'h0, "R11 cause cleared");
      bus_read(8'(8'h20 + 4 * b), 32'h0, "R11 enable cleared");
    end
    chk_parent('0, "R11 all lines low");

    idle(3);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule